// File: doc/BRIEF.md
# Atomic Set/Clear/Toggle GPIO Port

This block controls a port of up to 32 general-purpose pins through a small memory-mapped register bus. Software holds a full output word and a direction word, and can also change single output bits with one write to a set, clear or toggle strobe address. Each strobe touches only the bits written as 1, so separate tasks can change separate pins without a read-modify-write race.

Pin levels come back through a synchronizer into an input word. That word shows zero for pins that are not in digital use, as given by a per-pin enable mask. It freezes while the port-enable input is low. A parameter lists the pins that exist. Pins that do not exist are never driven and always read zero.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads 0x00000000 and both `pin_oe` and `pin_out` are all zero.
- R2: A write to offset 0x00 replaces the whole output-data word on that clock edge, and a read of 0x00 returns it.
- R3: A write to offset 0x04 sets to 1 each output-data bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x08 clears to 0 each output-data bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x0C inverts each output-data bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: Reads of the strobe offsets 0x04, 0x08 and 0x0C return zero.
- R7: Offset 0x14 holds the direction word and can be read and written. `pin_oe` equals that word, and `pin_out` bit i carries output-data bit i when direction bit i is 1 and carries 0 when it is 0.
- R8: Offset 0x10 reads `pin_in & dig_en`. A pin change becomes visible there on the third rising edge after it occurs, and writes to 0x10 change nothing.
- R9: While `port_en` is 0 the input word holds its value. It resumes sampling once `port_en` returns to 1.
- R10: Pins whose bit in the implemented-pin mask parameter is 0 read 0 in the output-data, direction and input words, and are never driven or enabled.
- R11: Reads of any other address, misaligned ones included, return zero, and writes to those addresses change no register.
- R12: `bus_rdata` is zero in every cycle where `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| pin_in | input | N_PINS | Raw pin levels, asynchronous |
| dig_en | input | N_PINS | Per-pin mask, 1 when the pin is in digital use |
| port_en | input | 1 | Port enable; while low the input word is frozen |
| pin_out | output | N_PINS | Output level for each pin |
| pin_oe | output | N_PINS | Output enable for each pin |

## Verification
The bench runs random sequences of set, clear, toggle, full-word and direction writes with random patterns. This exposes a strobe that writes the whole word instead of merging: bits that should hold would fall to zero or rise to one. It times the synchronizer exactly, so an extra or missing stage shows as a value arriving one edge early or late. It also changes pins while the port is disabled, to catch an input word that keeps sampling. Writes to the input address and to unmapped or misaligned addresses must leave the output and direction words unchanged. Unimplemented pins must stay at zero even after set and toggle writes of all ones.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int unsigned BUS_DATA_W = 32;

   // Byte offsets of the register window
   localparam int unsigned OFS_OUT  = 'h00;
   localparam int unsigned OFS_SET  = 'h04;
   localparam int unsigned OFS_CLR  = 'h08;
   localparam int unsigned OFS_TGL  = 'h0C;
   localparam int unsigned OFS_IN   = 'h10;
   localparam int unsigned OFS_DIR  = 'h14;
   localparam int unsigned OFS_SPAN = 'h18;

   typedef enum logic [2:0] {
      SEL_OUT,
      SEL_SET,
      SEL_CLR,
      SEL_TGL,
      SEL_IN,
      SEL_DIR,
      SEL_NONE
   } gpio_sel_e;

   typedef struct packed {
      logic out_wr;
      logic set_wr;
      logic clr_wr;
      logic tgl_wr;
      logic dir_wr;
   } gpio_wr_s;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
   import gpio_port_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output gpio_wr_s          wr_hit,
   output gpio_sel_e         sel
);

   initial begin
      if (ADDR_W < $clog2(OFS_SPAN))
         $error("gpio_bus_decode: ADDR_W too small for register window");
   end

   always_comb begin
      if      (addr == ADDR_W'(OFS_OUT)) sel = SEL_OUT;
      else if (addr == ADDR_W'(OFS_SET)) sel = SEL_SET;
      else if (addr == ADDR_W'(OFS_CLR)) sel = SEL_CLR;
      else if (addr == ADDR_W'(OFS_TGL)) sel = SEL_TGL;
      else if (addr == ADDR_W'(OFS_IN))  sel = SEL_IN;
      else if (addr == ADDR_W'(OFS_DIR)) sel = SEL_DIR;
      else                               sel = SEL_NONE;
   end

   always_comb begin
      wr_hit        = '0;
      wr_hit.out_wr = wr && (sel == SEL_OUT);
      wr_hit.set_wr = wr && (sel == SEL_SET);
      wr_hit.clr_wr = wr && (sel == SEL_CLR);
      wr_hit.tgl_wr = wr && (sel == SEL_TGL);
      wr_hit.dir_wr = wr && (sel == SEL_DIR);
   end

endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
   import gpio_port_pkg::*;
#(
   parameter int unsigned          N_PINS    = 32,
   parameter logic [N_PINS-1:0]    IMPL_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  gpio_wr_s          wr_hit,
   input  logic [N_PINS-1:0] wdata,
   output logic [N_PINS-1:0] out_q,
   output logic [N_PINS-1:0] dir_q
);

   // One generate slice per pin; absent pins collapse to constants.
   for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      if (IMPL_MASK[i]) begin : g_live
         logic out_nxt;

         always_comb begin
            out_nxt = out_q[i];
            unique case (1'b1)
               wr_hit.out_wr: out_nxt = wdata[i];
               wr_hit.set_wr: out_nxt = out_q[i] | wdata[i];
               wr_hit.clr_wr: out_nxt = out_q[i] & ~wdata[i];
               wr_hit.tgl_wr: out_nxt = out_q[i] ^ wdata[i];
               default:       out_nxt = out_q[i];
            endcase
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_q[i] <= 1'b0;
               dir_q[i] <= 1'b0;
            end else begin
               out_q[i] <= out_nxt;
               if (wr_hit.dir_wr) dir_q[i] <= wdata[i];
            end
         end
      end else begin : g_absent
         assign out_q[i] = 1'b0;
         assign dir_q[i] = 1'b0;
      end
   end

endmodule

// File: rtl/gpio_in_capture.sv
module gpio_in_capture #(
   parameter int unsigned       N_PINS      = 32,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [N_PINS-1:0] IMPL_MASK   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pin_in,
   input  logic [N_PINS-1:0] dig_en,
   input  logic              port_en,
   output logic [N_PINS-1:0] in_q
);

   initial begin
      if (SYNC_STAGES < 2)
         $error("gpio_in_capture: SYNC_STAGES must be at least 2");
   end

   logic [N_PINS-1:0] sync_r [SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) sync_r[s] <= '0;
      end else begin
         sync_r[0] <= pin_in;
         for (int s = 1; s < SYNC_STAGES; s++) sync_r[s] <= sync_r[s-1];
      end
   end

   for (genvar i = 0; i < N_PINS; i++) begin : g_cap
      if (IMPL_MASK[i]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       in_q[i] <= 1'b0;
            else if (port_en) in_q[i] <= sync_r[SYNC_STAGES-1][i] & dig_en[i];
         end
      end else begin : g_absent
         assign in_q[i] = 1'b0;
      end
   end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned       N_PINS      = 32,
   parameter int unsigned       ADDR_W      = 8,
   parameter int unsigned       DATA_W      = BUS_DATA_W,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [N_PINS-1:0] IMPL_MASK   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_PINS-1:0] pin_in,
   input  logic [N_PINS-1:0] dig_en,
   input  logic              port_en,
   output logic [N_PINS-1:0] pin_out,
   output logic [N_PINS-1:0] pin_oe
);

   initial begin
      if (N_PINS < 1 || N_PINS > DATA_W)
         $error("gpio_port: N_PINS must be in 1..DATA_W");
   end

   gpio_wr_s          wr_hit;
   gpio_sel_e         rd_sel;
   logic [N_PINS-1:0] out_q;
   logic [N_PINS-1:0] dir_q;
   logic [N_PINS-1:0] in_q;

   gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr   (bus_addr),
      .wr     (bus_wr),
      .wr_hit (wr_hit),
      .sel    (rd_sel)
   );

   gpio_out_bank #(.N_PINS(N_PINS), .IMPL_MASK(IMPL_MASK)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit),
      .wdata  (bus_wdata[N_PINS-1:0]),
      .out_q  (out_q),
      .dir_q  (dir_q)
   );

   gpio_in_capture #(
      .N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES), .IMPL_MASK(IMPL_MASK)
   ) u_in (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (pin_in),
      .dig_en  (dig_en),
      .port_en (port_en),
      .in_q    (in_q)
   );

   assign pin_oe  = dir_q;
   assign pin_out = out_q & dir_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (rd_sel)
            SEL_OUT: bus_rdata[N_PINS-1:0] = out_q;
            SEL_IN:  bus_rdata[N_PINS-1:0] = in_q;
            SEL_DIR: bus_rdata[N_PINS-1:0] = dir_q;
            default: bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
   import gpio_port_pkg::*;
#(
   parameter int unsigned       N_PINS    = 32,
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       DATA_W    = 32,
   parameter logic [N_PINS-1:0] IMPL_MASK = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              port_en,
   input logic [N_PINS-1:0] out_q,
   input logic [N_PINS-1:0] dir_q,
   input logic [N_PINS-1:0] in_q
);

   logic is_out, is_set, is_clr, is_tgl, is_in, is_dir, is_map;
   assign is_out = bus_addr == ADDR_W'(OFS_OUT);
   assign is_set = bus_addr == ADDR_W'(OFS_SET);
   assign is_clr = bus_addr == ADDR_W'(OFS_CLR);
   assign is_tgl = bus_addr == ADDR_W'(OFS_TGL);
   assign is_in  = bus_addr == ADDR_W'(OFS_IN);
   assign is_dir = bus_addr == ADDR_W'(OFS_DIR);
   assign is_map = is_out | is_set | is_clr | is_tgl | is_in | is_dir;

   a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && is_out) |=> out_q == ($past(bus_wdata[N_PINS-1:0]) & IMPL_MASK));

   a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && is_set) |=>
         out_q == (($past(out_q) | $past(bus_wdata[N_PINS-1:0])) & IMPL_MASK));

   a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && is_clr) |=> out_q == ($past(out_q) & ~$past(bus_wdata[N_PINS-1:0])));

   a_r5_tgl_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && is_tgl) |=>
         out_q == (($past(out_q) ^ $past(bus_wdata[N_PINS-1:0])) & IMPL_MASK));

   a_r6_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (is_set || is_clr || is_tgl)) |-> bus_rdata == '0);

   a_r8_in_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && is_in) |=> ($stable(out_q) && $stable(dir_q)));

   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> $stable(in_q));

   a_r11_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !is_map) |=> ($stable(out_q) && $stable(dir_q)));

   a_r12_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0);

endmodule

bind gpio_port gpio_port_chk #(
   .N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .port_en   (port_en),
   .out_q     (out_q),
   .dir_q     (dir_q),
   .in_q      (in_q)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;

   localparam int unsigned N = 32;
   localparam logic [31:0] MASK = 32'hFFFF_7FFE;   // pins 0 and 15 absent

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] dig_en = '0;
   logic        port_en = 1'b0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   bit          done = 1'b0;
   logic [31:0] m_out = '0;
   logic [31:0] m_dir = '0;
   logic [31:0] rd_val;
   logic [31:0] frozen;

   always #5 clk = ~clk;

   gpio_port #(.N_PINS(N), .ADDR_W(8), .DATA_W(32), .IMPL_MASK(MASK)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .dig_en(dig_en), .port_en(port_en),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   function automatic logic [31:0] f_apply(input logic [7:0] a, input logic [31:0] cur,
                                           input logic [31:0] w);
      case (a)
         8'h00:   return w & MASK;
         8'h04:   return (cur | w) & MASK;
         8'h08:   return cur & ~w;
         8'h0C:   return (cur ^ w) & MASK;
         default: return cur;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == 8'h14) m_dir = d & MASK;
      else            m_out = f_apply(a, m_out, d);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic check_state(input string req);
      logic [31:0] v;
      rd(8'h00, v); check({req, " out word"}, v, m_out);
      rd(8'h14, v); check({req, " dir word"}, v, m_dir);
      check({req, " pin_oe"}, pin_oe, m_dir);
      check({req, " pin_out"}, pin_out, m_out & m_dir);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5678));
      repeat (3) @(negedge clk);
      // R1: reset state
      rd(8'h00, rd_val); check("R1 out", rd_val, 0);
      rd(8'h14, rd_val); check("R1 dir", rd_val, 0);
      rd(8'h10, rd_val); check("R1 in", rd_val, 0);
      check("R1 pin_oe", pin_oe, 0);
      check("R1 pin_out", pin_out, 0);
      rst_n = 1'b1;

      // R2 / R10: full writes, absent pins stay zero
      wr(8'h00, 32'hFFFF_FFFF); check_state("R2 R10 all ones");
      wr(8'h14, 32'hFFFF_FFFF); check_state("R7 R10 dir all ones");
      wr(8'h00, 32'h0000_0000); check_state("R2 zero");
      wr(8'h04, 32'hFFFF_FFFF); check_state("R3 R10 set all");
      wr(8'h08, 32'h00FF_00FF); check_state("R4 clr half");
      wr(8'h0C, 32'hFFFF_FFFF); check_state("R5 R10 tgl all");
      wr(8'h04, 32'h0000_0000); check_state("R3 set zero no effect");
      wr(8'h08, 32'h0000_0000); check_state("R4 clr zero no effect");
      wr(8'h0C, 32'h0000_0000); check_state("R5 tgl zero no effect");

      // R6: strobe reads
      rd(8'h04, rd_val); check("R6 set reads zero", rd_val, 0);
      rd(8'h08, rd_val); check("R6 clr reads zero", rd_val, 0);
      rd(8'h0C, rd_val); check("R6 tgl reads zero", rd_val, 0);

      // R12: no read, no data
      @(negedge clk); bus_addr = 8'h14; bus_rd = 1'b0;
      #1 check("R12 idle rdata", bus_rdata, 0);

      // Random mix of writes (R2 R3 R4 R5 R7)
      for (int k = 0; k < 300; k++) begin
         logic [7:0] a;
         logic [31:0] d;
         case ($urandom_range(0, 4))
            0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C; default: a = 8'h14;
         endcase
         d = $urandom;
         wr(a, d);
         check_state("R2 R3 R4 R5 R7 random");
      end

      // R11: unmapped and misaligned addresses
      wr(8'h18, 32'hFFFF_FFFF); check_state("R11 write 0x18");
      wr(8'h02, 32'hA5A5_A5A5); check_state("R11 write 0x02");
      wr(8'hFC, 32'h5A5A_5A5A); check_state("R11 write 0xFC");
      rd(8'h18, rd_val); check("R11 read 0x18", rd_val, 0);
      rd(8'h01, rd_val); check("R11 read 0x01", rd_val, 0);

      // R8: input path, masking and latency
      port_en = 1'b1;
      dig_en  = 32'hFFFF_FFFF;
      @(negedge clk); pin_in = 32'hFFFF_FFFF;
      @(negedge clk); @(negedge clk);
      #1 bus_addr = 8'h10; bus_rd = 1'b1;
      #1 check("R8 two edges not yet", bus_rdata, 0);
      bus_rd = 1'b0;
      @(negedge clk);
      bus_addr = 8'h10; bus_rd = 1'b1;
      #1 check("R8 R10 third edge", bus_rdata, MASK);
      bus_rd = 1'b0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         pin_in = $urandom; dig_en = $urandom;
         repeat (3) @(negedge clk);
         rd(8'h10, rd_val);
         check("R8 masked input", rd_val, pin_in & dig_en & MASK);
      end
      wr(8'h10, 32'hFFFF_FFFF); check_state("R8 write to input ignored");
      rd(8'h10, rd_val); check("R8 input after write", rd_val, pin_in & dig_en & MASK);

      // R9: freeze while disabled
      frozen = pin_in & dig_en & MASK;
      @(negedge clk); port_en = 1'b0; pin_in = ~pin_in;
      repeat (6) @(negedge clk);
      rd(8'h10, rd_val); check("R9 frozen", rd_val, frozen);
      port_en = 1'b1;
      repeat (4) @(negedge clk);
      rd(8'h10, rd_val); check("R9 resumes", rd_val, pin_in & dig_en & MASK);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule